// File: doc/BRIEF.md
# Drift-Adjustable Precision Time Counter

This block keeps a free-running 64-bit time value for packet timestamping. In the normal case the time counter advances by a fixed nominal increment on every clock. Timestamp capture logic reads the running value from `time_now`.

Software steers the count through one command strobe. The strobe carries two independent operations, and both can act in the same command. The first is a drift operation, which corrects frequency. It stores a small signed step and a period in clock cycles, and the step is then added to or taken from the nominal increment once per period. The second is an offset operation, which corrects phase. It adds a 64-bit delta to the time, or subtracts it, in a single clock. The block confirms each command with a one-cycle completion pulse.

All time arithmetic is modulo 2^64. The nominal increment defaults to 8 units per clock.

Top module: `phc_drift_clock`

## Requirements
- R1: While `rst_n` is low, and after it returns high, `time_now` is 0, `cmd_done` is 0 and no drift settings are stored. After reset, the time advances only by the nominal increment.
- R2: In a clock edge with no offset operation and no drift step, `time_now` grows by exactly `NOM_INC`, which is 8 by default.
- R3: Drift field `drift_op` = 1 stores `drift_dir`, `drift_step_val` (8 bits) and `drift_period` (32 bits), and restarts the cycle counter. With period P > 0, the first drift step falls on the P-th clock edge after the command edge, and a step follows every P edges after that. A step adds the stored value when the stored direction is 1 and subtracts it when the direction is 0.
- R4: New drift settings take effect on the edge after the command edge. The command edge itself still uses the settings held before it, including any step that was due on that edge.
- R5: Drift field `drift_op` = 2 clears the stored value, direction and period. From then on only the nominal increment is used.
- R6: A stored drift period of 0 disables drift steps entirely.
- R7: Offset field `offset_op` = 1 adds the 64-bit delta {`offset_hi`, `offset_lo`} to the time, and `offset_op` = 2 subtracts it, modulo 2^64. The change shows in `time_now` right after the command edge.
- R8: When an offset operation and a drift step fall on the same edge, the increment on that edge is the nominal value, plus or minus the drift value, plus or minus the delta.
- R9: The reserved code 3 in either operation field has no effect: no stored setting changes and the time is not offset.
- R10: `cmd_done` is high for exactly one cycle, during the second cycle after the command edge. Commands on consecutive cycles each produce their own pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Registered one-cycle command strobe |
| drift_op | input | 2 | Drift operation: 0 keep, 1 load, 2 clear, 3 reserved |
| offset_op | input | 2 | Offset operation: 0 hold, 1 add, 2 subtract, 3 reserved |
| drift_dir | input | 1 | Drift direction: 1 adds, 0 subtracts |
| drift_step_val | input | 8 | Magnitude of the drift step |
| drift_period | input | 32 | Cycles between drift steps; 0 disables drift |
| offset_lo | input | 32 | Low half of the offset delta |
| offset_hi | input | 32 | High half of the offset delta |
| cmd_done | output | 1 | Completion pulse, two cycles after the command edge |
| time_now | output | 64 | Current time value |

## Verification
An offset becomes visible in `time_now` right after the command edge. Newly loaded drift first affects the time P edges after the command edge. `cmd_done` rises two edges after the command edge. The bench drives commands and samples outputs on falling edges. For each command it records the time just before the command edge, lets a known number of edges pass, and compares the difference with a hand-derived total of nominal increments, drift steps and offset. It samples `cmd_done` at the falling edges after the command edge and the next two edges, so the pulse must fall exactly in the second one.

// File: rtl/phc_pkg.sv
package phc_pkg;

  typedef enum logic [1:0] {
    DRIFT_KEEP  = 2'd0,
    DRIFT_LOAD  = 2'd1,
    DRIFT_CLEAR = 2'd2
  } drift_op_e;

  typedef enum logic [1:0] {
    OFS_HOLD = 2'd0,
    OFS_ADD  = 2'd1,
    OFS_SUB  = 2'd2
  } offset_op_e;

  localparam int unsigned DONE_LAT = 2;

endpackage

// File: rtl/phc_cmd_decode.sv
module phc_cmd_decode
  import phc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] drift_op,
  input  logic [1:0] offset_op,
  output logic       drift_load,
  output logic       drift_clear,
  output logic       ofs_add,
  output logic       ofs_sub,
  output logic       cmd_done
);

  // operation decode; reserved codes decode to nothing
  always_comb begin
    drift_load  = cmd_valid && (drift_op  == DRIFT_LOAD);
    drift_clear = cmd_valid && (drift_op  == DRIFT_CLEAR);
    ofs_add     = cmd_valid && (offset_op == OFS_ADD);
    ofs_sub     = cmd_valid && (offset_op == OFS_SUB);
  end

  // completion delay line, one flop per stage
  generate
    for (genvar g = 0; g < DONE_LAT; g++) begin : g_done
      logic q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= cmd_valid;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= 1'b0;
          else        q <= g_done[g-1].q;
        end
      end
    end
  endgenerate

  assign cmd_done = g_done[DONE_LAT-1].q;

endmodule

// File: rtl/phc_drift_sched.sv
module phc_drift_sched #(
  parameter int unsigned DRIFT_W  = 8,
  parameter int unsigned PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drift_load,
  input  logic                drift_clear,
  input  logic                dir_in,
  input  logic [DRIFT_W-1:0]  val_in,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                drift_step,
  output logic                dir_q,
  output logic [DRIFT_W-1:0]  val_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic [PERIOD_W-1:0] period_cnt
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  function automatic logic step_due(input logic [PERIOD_W-1:0] per,
                                    input logic [PERIOD_W-1:0] cnt);
    return (per != '0) && (cnt == per - ONE);
  endfunction

  assign drift_step = step_due(period_q, period_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      val_q    <= '0;
      period_q <= '0;
    end else if (drift_load) begin
      dir_q    <= dir_in;
      val_q    <= val_in;
      period_q <= period_in;
    end else if (drift_clear) begin
      dir_q    <= 1'b0;
      val_q    <= '0;
      period_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            period_cnt <= '0;
    else if (drift_load || drift_clear)    period_cnt <= '0;
    else if (period_q == '0 || drift_step) period_cnt <= '0;
    else                                   period_cnt <= period_cnt + ONE;
  end

endmodule

// File: rtl/phc_time_acc.sv
module phc_time_acc #(
  parameter int unsigned TIME_W  = 64,
  parameter int unsigned DRIFT_W = 8,
  parameter int unsigned NOM_INC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               drift_step,
  input  logic               dir_q,
  input  logic [DRIFT_W-1:0] val_q,
  input  logic               ofs_add,
  input  logic               ofs_sub,
  input  logic [TIME_W-1:0]  delta,
  output logic [TIME_W-1:0]  time_q
);

  localparam logic [TIME_W-1:0] NOM = TIME_W'(NOM_INC);

  function automatic logic [TIME_W-1:0] drift_term(input logic step,
                                                   input logic dir,
                                                   input logic [DRIFT_W-1:0] v);
    logic [TIME_W-1:0] ext;
    ext = {{(TIME_W-DRIFT_W){1'b0}}, v};
    if (!step)    return '0;
    else if (dir) return ext;
    else          return '0 - ext;
  endfunction

  function automatic logic [TIME_W-1:0] offset_term(input logic add,
                                                    input logic sub,
                                                    input logic [TIME_W-1:0] d);
    if (add)      return d;
    else if (sub) return '0 - d;
    else          return '0;
  endfunction

  logic [TIME_W-1:0] time_nx;
  assign time_nx = time_q + NOM + drift_term(drift_step, dir_q, val_q)
                 + offset_term(ofs_add, ofs_sub, delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_nx;
  end

endmodule

// File: rtl/phc_drift_clock.sv
module phc_drift_clock #(
  parameter int unsigned TIME_W   = 64,
  parameter int unsigned DRIFT_W  = 8,
  parameter int unsigned PERIOD_W = 32,
  parameter int unsigned NOM_INC  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            drift_op,
  input  logic [1:0]            offset_op,
  input  logic                  drift_dir,
  input  logic [DRIFT_W-1:0]    drift_step_val,
  input  logic [PERIOD_W-1:0]   drift_period,
  input  logic [TIME_W/2-1:0]   offset_lo,
  input  logic [TIME_W/2-1:0]   offset_hi,
  output logic                  cmd_done,
  output logic [TIME_W-1:0]     time_now
);

  logic                drift_load, drift_clear, ofs_add, ofs_sub;
  logic                drift_step, dir_q;
  logic [DRIFT_W-1:0]  drift_val_q;
  logic [PERIOD_W-1:0] period_q, period_cnt;
  logic [TIME_W-1:0]   delta;

  assign delta = {offset_hi, offset_lo};

  phc_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .drift_op   (drift_op),
    .offset_op  (offset_op),
    .drift_load (drift_load),
    .drift_clear(drift_clear),
    .ofs_add    (ofs_add),
    .ofs_sub    (ofs_sub),
    .cmd_done   (cmd_done)
  );

  phc_drift_sched #(.DRIFT_W(DRIFT_W), .PERIOD_W(PERIOD_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .drift_load (drift_load),
    .drift_clear(drift_clear),
    .dir_in     (drift_dir),
    .val_in     (drift_step_val),
    .period_in  (drift_period),
    .drift_step (drift_step),
    .dir_q      (dir_q),
    .val_q      (drift_val_q),
    .period_q   (period_q),
    .period_cnt (period_cnt)
  );

  phc_time_acc #(.TIME_W(TIME_W), .DRIFT_W(DRIFT_W), .NOM_INC(NOM_INC)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .drift_step(drift_step),
    .dir_q     (dir_q),
    .val_q     (drift_val_q),
    .ofs_add   (ofs_add),
    .ofs_sub   (ofs_sub),
    .delta     (delta),
    .time_q    (time_now)
  );

endmodule

// File: rtl/phc_drift_clock_chk.sv
module phc_drift_clock_chk #(
  parameter int unsigned TIME_W   = 64,
  parameter int unsigned DRIFT_W  = 8,
  parameter int unsigned PERIOD_W = 32,
  parameter int unsigned NOM_INC  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          drift_op,
  input logic                cmd_done,
  input logic [TIME_W-1:0]   time_now,
  input logic                drift_step,
  input logic                ofs_add,
  input logic                ofs_sub,
  input logic [DRIFT_W-1:0]  drift_val_q,
  input logic [PERIOD_W-1:0] period_q,
  input logic [PERIOD_W-1:0] period_cnt
);

  assert_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!drift_step && !ofs_add && !ofs_sub) |=>
      (time_now == $past(time_now) + TIME_W'(NOM_INC)));

  assert_step_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drift_step |=> (period_cnt == '0));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && drift_op == 2'd2) |=> (period_q == '0 && drift_val_q == '0));

  assert_zero_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drift_step |-> (period_q != '0));

  assert_offset_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ofs_add, ofs_sub}));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && drift_op == 2'd3) |=> ($stable(period_q) && $stable(drift_val_q)));

  assert_done_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ##2 cmd_done);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(cmd_valid, 2));

endmodule

bind phc_drift_clock phc_drift_clock_chk #(
  .TIME_W(TIME_W), .DRIFT_W(DRIFT_W), .PERIOD_W(PERIOD_W), .NOM_INC(NOM_INC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .drift_op   (drift_op),
  .cmd_done   (cmd_done),
  .time_now   (time_now),
  .drift_step (drift_step),
  .ofs_add    (ofs_add),
  .ofs_sub    (ofs_sub),
  .drift_val_q(drift_val_q),
  .period_q   (period_q),
  .period_cnt (period_cnt)
);

// File: tb/test_phc_drift_clock.sv
module test_phc_drift_clock;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [1:0]  dc;
    logic [1:0]  oc;
    logic        dir;
    logic [7:0]  val;
    logic [31:0] per;
    logic [63:0] delta;
    logic [7:0]  n;
    logic [63:0] exp;
    logic [3:0]  req;
  } vec_t;

  // expected = time gained from just before the command edge to after n edges
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 2'd0, 1'b1, 8'd3,  32'd4, 64'd0,                   8'd8,  64'd67,                  4'd3},
    '{2'd1, 2'd1, 1'b0, 8'd2,  32'd3, 64'd1000,                8'd7,  64'd1055,                4'd8},
    '{2'd2, 2'd2, 1'b0, 8'd0,  32'd0, 64'h0000_0001_0000_0005, 8'd5,  64'hFFFF_FFFF_0000_0023, 4'd7},
    '{2'd0, 2'd1, 1'b0, 8'd0,  32'd0, 64'd7,                   8'd6,  64'd55,                  4'd7},
    '{2'd3, 2'd3, 1'b1, 8'd50, 32'd2, 64'd99,                  8'd6,  64'd48,                  4'd9},
    '{2'd1, 2'd0, 1'b1, 8'd5,  32'd0, 64'd0,                   8'd10, 64'd80,                  4'd6},
    '{2'd1, 2'd0, 1'b1, 8'd1,  32'd1, 64'd0,                   8'd5,  64'd44,                  4'd3},
    '{2'd0, 2'd1, 1'b0, 8'd0,  32'd0, 64'h0000_0002_0000_0000, 8'd3,  64'h0000_0002_0000_001B, 4'd8},
    '{2'd1, 2'd0, 1'b0, 8'd20, 32'd2, 64'd0,                   8'd4,  64'd13,                  4'd4},
    '{2'd2, 2'd0, 1'b0, 8'd0,  32'd0, 64'd0,                   8'd4,  64'd12,                  4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  drift_op = '0;
  logic [1:0]  offset_op = '0;
  logic        drift_dir = 1'b0;
  logic [7:0]  drift_step_val = '0;
  logic [31:0] drift_period = '0;
  logic [31:0] offset_lo = '0;
  logic [31:0] offset_hi = '0;
  logic        cmd_done;
  logic [63:0] time_now;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phc_drift_clock i_phc_drift_clock (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .drift_op(drift_op),
    .offset_op(offset_op), .drift_dir(drift_dir), .drift_step_val(drift_step_val),
    .drift_period(drift_period), .offset_lo(offset_lo), .offset_hi(offset_hi),
    .cmd_done(cmd_done), .time_now(time_now)
  );

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_cmd(input vec_t v);
    drift_op = v.dc; offset_op = v.oc; drift_dir = v.dir;
    drift_step_val = v.val; drift_period = v.per;
    offset_lo = v.delta[31:0]; offset_hi = v.delta[63:32];
    cmd_valid = 1'b1;
  endtask

  initial begin
    logic [63:0] t0;
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1", time_now, 64'd0);
    check("R1", {63'd0, cmd_done}, 64'd0);
    rst_n = 1'b1;
    t0 = time_now;
    repeat (5) @(negedge clk);
    check("R2", time_now - t0, 64'd40);

    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      t0 = time_now;
      put_cmd(v);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10", {63'd0, cmd_done}, 64'd0);
      for (int j = 1; j < int'(v.n); j++) begin
        @(negedge clk);
        if (j == 1) check("R10", {63'd0, cmd_done}, 64'd1);
        if (j == 2) check("R10", {63'd0, cmd_done}, 64'd0);
      end
      check(req_name(v.req), time_now - t0, v.exp);
    end

    // back-to-back offset commands, drift cleared
    t0 = time_now;
    put_cmd('{2'd0, 2'd1, 1'b0, 8'd0, 32'd0, 64'd10, 8'd0, 64'd0, 4'd0});
    @(negedge clk);
    check("R10", {63'd0, cmd_done}, 64'd0);
    put_cmd('{2'd0, 2'd1, 1'b0, 8'd0, 32'd0, 64'd20, 8'd0, 64'd0, 4'd0});
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10", {63'd0, cmd_done}, 64'd1);
    @(negedge clk);
    check("R10", {63'd0, cmd_done}, 64'd1);
    @(negedge clk);
    check("R10", {63'd0, cmd_done}, 64'd0);
    check("R7", time_now - t0, 64'd62);

    // reset in the middle of operation with drift loaded
    put_cmd('{2'd1, 2'd0, 1'b1, 8'd7, 32'd2, 64'd0, 8'd0, 64'd0, 4'd0});
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", time_now, 64'd0);
    check("R1", {63'd0, cmd_done}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", time_now, 64'd32);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule